// File: doc/BRIEF.md
# Word Latch with Literal Loading and Condition Flags

This block holds the dock's word-wide data register together with its three condition flags. A word reaches the register in one of three ways. It can be captured whole from the data input. It can be loaded from a 13-bit literal padded above with zeros or with ones. Or it can be shifted in 19 bits at a time, so that a constant wider than one instruction's literal field is assembled over several steps. A literal is first taken into a staging register when its instruction comes on deck. It reaches the data register only when that instruction later executes, so the instruction field may change in between.

The flags are A, B and C. A and B are rewritten together by a flag-update strobe. Each new value is the OR of any chosen subset of the six terms A, not-A, B, not-B, C and not-C, all taken from the values before the update. C is written by a transfer strobe. Its source is either the signal bit of the arriving packet or a status bit from the attached unit. Which one depends on the transfer kind and on whether the dock faces inward or outward, and that choice is fixed by a parameter.

Top module: `word_flag_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state has `word_q` = 0 and all three flags at 0.
- R2: The staging register loads only in a cycle with `ondeck_load` high. A later change of the literal inputs has no effect on what a following literal execute writes. A staging load alone leaves `word_q` unchanged.
- R3: When `ondeck_shift_form`=0 and `ondeck_ones_fill`=0, a later `exe_lit_load` writes `word_q` = {24 zeros, imm[12:0]}. Bits imm[18:13] are ignored.
- R4: When `ondeck_shift_form`=0 and `ondeck_ones_fill`=1, a later `exe_lit_load` writes `word_q` = {24 ones, imm[12:0]}.
- R5: When `ondeck_shift_form`=1, a later `exe_lit_shift` writes `word_q` = {old word_q[17:0], imm[18:0]}.
- R6: `exe_word_capture` writes `word_in` into `word_q` on the next edge.
- R7: On `exe_flag_update`, each of A and B becomes the OR of the terms its 6-bit select chooses. The select bits are bit5=A, bit4=not-A, bit3=B, bit2=not-B, bit1=C and bit0=not-C. An all-zero select gives 0.
- R8: Selecting a flag together with its complement gives 1. Selecting only A for A (6'b100000) and only B for B (6'b001000) leaves both flags unchanged.
- R9: A and B are both computed from the pre-update flags, so the selects A←B and B←A swap them. Also, an update that reads C in the same cycle as a C write sees the old C.
- R10: With `OUT_DOCK`=0, `exe_transfer` with `xfer_data_in` or `xfer_token_in` set loads C from `pkt_signal`. `ship_status` is ignored.
- R11: With `OUT_DOCK`=1, `exe_transfer` with `xfer_data_in` set loads C from `ship_status`. With only `xfer_token_in` set, it loads C from `pkt_signal`.
- R12: `exe_transfer` with neither `xfer_data_in` nor `xfer_token_in` set leaves C unchanged.
- R13: When word-write strobes coincide, literal load wins over shift, and shift wins over capture. With no word-write strobe, `word_q` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ondeck_load | input | 1 | Capture the literal into the staging register |
| ondeck_shift_form | input | 1 | 1: 19-bit shift literal, 0: 13-bit padded literal |
| ondeck_ones_fill | input | 1 | Pad the 13-bit literal with ones instead of zeros |
| ondeck_imm | input | SHIFT_W (19) | Literal field of the instruction coming on deck |
| exe_lit_load | input | 1 | Execute: staged padded literal to the word register |
| exe_lit_shift | input | 1 | Execute: shift the staged literal into the word register |
| exe_word_capture | input | 1 | Execute: capture `word_in` |
| word_in | input | WORD_W (37) | Incoming data word |
| exe_flag_update | input | 1 | Execute: rewrite A and B |
| a_select | input | 6 | OR-select terms for new A |
| b_select | input | 6 | OR-select terms for new B |
| exe_transfer | input | 1 | Execute: transfer, may write C |
| xfer_data_in | input | 1 | Transfer consumes a data input |
| xfer_token_in | input | 1 | Transfer consumes a token input |
| pkt_signal | input | 1 | Signal bit of the arriving packet |
| ship_status | input | 1 | Status bit from the attached unit |
| word_q | output | WORD_W (37) | Data register value |
| flag_a | output | 1 | Flag A |
| flag_b | output | 1 | Flag B |
| flag_c | output | 1 | Flag C |

## Verification
Two effects are hard to see from the ports. One is that the staged literal comes apart from the instruction field after the on-deck capture. The other is that A and B read each other's old values. For the first, the stimulus loads the staging register and then overwrites the literal inputs with different values, including junk in the ignored upper bits, before the execute strobe. For the second, a walked table of flag vectors chains each update on the state the previous one left. It includes a swap, complement pairs, all-zero selects, and a flag update that reads C in the same cycle a transfer writes it. A second instance built as an outward-facing dock receives the same strobes, so the C-source choice can be compared between the two variants.

// File: rtl/wfu_pkg.sv
// Shared definitions for the word latch and flag unit.
// Assumes the flag select vector is exactly six bits with the fixed term order below.
package wfu_pkg;

    localparam int SEL_W  = 6;
    localparam int SEL_A  = 5;
    localparam int SEL_NA = 4;
    localparam int SEL_B  = 3;
    localparam int SEL_NB = 2;
    localparam int SEL_C  = 1;
    localparam int SEL_NC = 0;

    typedef logic [SEL_W-1:0] flag_sel_t;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } flags_t;

    typedef enum logic [1:0] {
        WR_HOLD,
        WR_LIT,
        WR_SHIFT,
        WR_CAPTURE
    } word_wr_e;

    // OR together every term picked by the select vector, using old flag values.
    function automatic logic sel_or(input flag_sel_t s, input flags_t f);
        return (s[SEL_A]  &  f.a) | (s[SEL_NA] & ~f.a) |
               (s[SEL_B]  &  f.b) | (s[SEL_NB] & ~f.b) |
               (s[SEL_C]  &  f.c) | (s[SEL_NC] & ~f.c);
    endfunction

endpackage

// File: rtl/wfu_literal.sv
// Staging register for literals. When an instruction comes on deck it
// captures either a zero-padded shift literal or a zero/ones-padded short
// literal, already widened to the word. Assumes SHIFT_W >= SET_W and WORD_W > SHIFT_W.
module wfu_literal #(
    parameter int WORD_W  = 37,
    parameter int SHIFT_W = 19,
    parameter int SET_W   = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               shift_form,
    input  logic               ones_fill,
    input  logic [SHIFT_W-1:0] imm,
    output logic [WORD_W-1:0]  lit_q
);
    localparam int SET_PAD   = WORD_W - SET_W;
    localparam int SHIFT_PAD = WORD_W - SHIFT_W;

    logic [WORD_W-1:0] lit_wide;

    // Widen the incoming literal according to its form.
    always_comb begin
        if (shift_form)
            lit_wide = {{SHIFT_PAD{1'b0}}, imm};
        else
            lit_wide = {{SET_PAD{ones_fill}}, imm[SET_W-1:0]};
    end

    // Hold the widened literal from on-deck time until execution.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lit_q <= '0;
        else if (load)
            lit_q <= lit_wide;
    end

endmodule

// File: rtl/wfu_word.sv
// Word-wide data register. It has three write sources with fixed priority:
// staged literal, shift-in of the staged literal's low bits, and capture of
// the input word. Assumes WORD_W > SHIFT_W.
module wfu_word #(
    parameter int WORD_W  = 37,
    parameter int SHIFT_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_lit,
    input  logic              do_shift,
    input  logic              do_capture,
    input  logic [WORD_W-1:0] lit,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_q
);
    import wfu_pkg::*;

    localparam int KEEP_W = WORD_W - SHIFT_W;

    word_wr_e          wr_sel;
    logic [WORD_W-1:0] word_nxt;

    // Resolve coinciding strobes: literal, then shift, then capture.
    always_comb begin
        if (do_lit)
            wr_sel = WR_LIT;
        else if (do_shift)
            wr_sel = WR_SHIFT;
        else if (do_capture)
            wr_sel = WR_CAPTURE;
        else
            wr_sel = WR_HOLD;
    end

    // Form the next register value for the chosen source.
    always_comb begin
        unique case (wr_sel)
            WR_LIT:     word_nxt = lit;
            WR_SHIFT:   word_nxt = {word_q[KEEP_W-1:0], lit[SHIFT_W-1:0]};
            WR_CAPTURE: word_nxt = word_in;
            default:    word_nxt = word_q;
        endcase
    end

    // Update the data register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else
            word_q <= word_nxt;
    end

endmodule

// File: rtl/wfu_flags.sv
// Three-flag register. A and B are rewritten together from OR-selects over
// the old flags. C is loaded during a transfer from the packet signal bit or
// the attached unit's status bit. OUT_DOCK picks the dock orientation.
module wfu_flags #(
    parameter bit OUT_DOCK = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                do_update,
    input  wfu_pkg::flag_sel_t  sel_a,
    input  wfu_pkg::flag_sel_t  sel_b,
    input  logic                do_xfer,
    input  logic                data_in,
    input  logic                token_in,
    input  logic                pkt_signal,
    input  logic                ship_status,
    output logic                flag_a,
    output logic                flag_b,
    output logic                flag_c
);
    import wfu_pkg::*;

    localparam int NUM_AB = 2;

    flags_t    cur;
    flag_sel_t sel_arr [NUM_AB];
    logic [NUM_AB-1:0] ab_q;
    logic [NUM_AB-1:0] ab_nxt;
    logic      c_load;
    logic      c_src;

    assign cur        = '{a: ab_q[0], b: ab_q[1], c: flag_c};
    assign sel_arr[0] = sel_a;
    assign sel_arr[1] = sel_b;

    // One OR-select evaluator per general-purpose flag, all reading old state.
    for (genvar i = 0; i < NUM_AB; i++) begin : g_ab
        assign ab_nxt[i] = sel_or(sel_arr[i], cur);
    end

    // Decide whether a transfer writes C and from which source.
    always_comb begin
        c_load = do_xfer && (data_in || token_in);
        c_src  = ((OUT_DOCK != 1'b0) && data_in) ? ship_status : pkt_signal;
    end

    // Rewrite A and B together on an update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ab_q <= '0;
        else if (do_update)
            ab_q <= ab_nxt;
    end

    // Load C on a qualifying transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_c <= 1'b0;
        else if (c_load)
            flag_c <= c_src;
    end

    assign flag_a = ab_q[0];
    assign flag_b = ab_q[1];

endmodule

// File: rtl/word_flag_unit.sv
// Top of the word latch and flag unit. It joins the literal staging register,
// the data register and the flag register. Callers assert at most the strobes
// of one instruction per cycle; coincident word writes are resolved by priority.
module word_flag_unit #(
    parameter int WORD_W   = 37,
    parameter int SHIFT_W  = 19,
    parameter int SET_W    = 13,
    parameter bit OUT_DOCK = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ondeck_load,
    input  logic               ondeck_shift_form,
    input  logic               ondeck_ones_fill,
    input  logic [SHIFT_W-1:0] ondeck_imm,
    input  logic               exe_lit_load,
    input  logic               exe_lit_shift,
    input  logic               exe_word_capture,
    input  logic [WORD_W-1:0]  word_in,
    input  logic               exe_flag_update,
    input  logic [5:0]         a_select,
    input  logic [5:0]         b_select,
    input  logic               exe_transfer,
    input  logic               xfer_data_in,
    input  logic               xfer_token_in,
    input  logic               pkt_signal,
    input  logic               ship_status,
    output logic [WORD_W-1:0]  word_q,
    output logic               flag_a,
    output logic               flag_b,
    output logic               flag_c
);
    logic [WORD_W-1:0] staged_lit;

    wfu_literal #(
        .WORD_W  (WORD_W),
        .SHIFT_W (SHIFT_W),
        .SET_W   (SET_W)
    ) u_literal (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ondeck_load),
        .shift_form (ondeck_shift_form),
        .ones_fill  (ondeck_ones_fill),
        .imm        (ondeck_imm),
        .lit_q      (staged_lit)
    );

    wfu_word #(
        .WORD_W  (WORD_W),
        .SHIFT_W (SHIFT_W)
    ) u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_lit     (exe_lit_load),
        .do_shift   (exe_lit_shift),
        .do_capture (exe_word_capture),
        .lit        (staged_lit),
        .word_in    (word_in),
        .word_q     (word_q)
    );

    wfu_flags #(
        .OUT_DOCK (OUT_DOCK)
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .do_update   (exe_flag_update),
        .sel_a       (a_select),
        .sel_b       (b_select),
        .do_xfer     (exe_transfer),
        .data_in     (xfer_data_in),
        .token_in    (xfer_token_in),
        .pkt_signal  (pkt_signal),
        .ship_status (ship_status),
        .flag_a      (flag_a),
        .flag_b      (flag_b),
        .flag_c      (flag_c)
    );

endmodule

// File: rtl/wfu_checker.sv
// Property checker for word_flag_unit, attached to every instance by bind.
// It observes only the top-level ports.
module wfu_checker #(
    parameter int WORD_W   = 37,
    parameter int SHIFT_W  = 19,
    parameter int SET_W    = 13,
    parameter bit OUT_DOCK = 1'b0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               exe_lit_load,
    input logic               exe_lit_shift,
    input logic               exe_word_capture,
    input logic [WORD_W-1:0]  word_in,
    input logic               exe_flag_update,
    input logic [5:0]         a_select,
    input logic [5:0]         b_select,
    input logic               exe_transfer,
    input logic               xfer_data_in,
    input logic               xfer_token_in,
    input logic               pkt_signal,
    input logic               ship_status,
    input logic [WORD_W-1:0]  word_q,
    input logic               flag_a,
    input logic               flag_b,
    input logic               flag_c
);
    localparam int KEEP_W = WORD_W - SHIFT_W;

    logic any_word_wr;
    assign any_word_wr = exe_lit_load || exe_lit_shift || exe_word_capture;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (word_q == '0 && !flag_a && !flag_b && !flag_c));

    assert_pad_uniform_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exe_lit_load |=> (word_q[WORD_W-1:SET_W] == '0 || word_q[WORD_W-1:SET_W] == '1));

    assert_shift_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_lit_shift && !exe_lit_load) |=> word_q[WORD_W-1:SHIFT_W] == $past(word_q[KEEP_W-1:0]));

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_word_capture && !exe_lit_shift && !exe_lit_load) |=> word_q == $past(word_in));

    assert_zero_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_flag_update && a_select == 6'b0 && b_select == 6'b0) |=> (!flag_a && !flag_b));

    assert_complement_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_flag_update && a_select[5] && a_select[4]) |=> flag_a);

    assert_self_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_flag_update && a_select == 6'b100000 && b_select == 6'b001000) |=> ($stable(flag_a) && $stable(flag_b)));

    assert_swap_old_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_flag_update && a_select == 6'b001000 && b_select == 6'b100000) |=> (flag_a == $past(flag_b) && flag_b == $past(flag_a)));

    assert_c_signal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_transfer && (OUT_DOCK == 1'b0 ? (xfer_data_in || xfer_token_in) : (!xfer_data_in && xfer_token_in)))
        |=> flag_c == $past(pkt_signal));

    assert_c_ship_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_transfer && xfer_data_in && OUT_DOCK != 1'b0) |=> flag_c == $past(ship_status));

    assert_c_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!exe_transfer || (!xfer_data_in && !xfer_token_in)) |=> $stable(flag_c));

    assert_word_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !any_word_wr |=> $stable(word_q));

endmodule

bind word_flag_unit wfu_checker #(
    .WORD_W   (WORD_W),
    .SHIFT_W  (SHIFT_W),
    .SET_W    (SET_W),
    .OUT_DOCK (OUT_DOCK)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .exe_lit_load     (exe_lit_load),
    .exe_lit_shift    (exe_lit_shift),
    .exe_word_capture (exe_word_capture),
    .word_in          (word_in),
    .exe_flag_update  (exe_flag_update),
    .a_select         (a_select),
    .b_select         (b_select),
    .exe_transfer     (exe_transfer),
    .xfer_data_in     (xfer_data_in),
    .xfer_token_in    (xfer_token_in),
    .pkt_signal       (pkt_signal),
    .ship_status      (ship_status),
    .word_q           (word_q),
    .flag_a           (flag_a),
    .flag_b           (flag_b),
    .flag_c           (flag_c)
);

// File: tb/word_flag_unit_tb.sv
`timescale 1ns/100ps
// Bench for word_flag_unit: directed word-path tests, a walked flag vector
// table, and outward-dock C-source tests on a second instance.
module word_flag_unit_tb;
    localparam int W = 37;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          od_load = 0, od_shift = 0, od_fill = 0;
    logic [18:0]   od_imm = '0;
    logic          ex_lit = 0, ex_shift = 0, ex_cap = 0;
    logic [W-1:0]  din = '0;
    logic          ex_flags = 0;
    logic [5:0]    sel_a = '0, sel_b = '0;
    logic          ex_move = 0, di = 0, ti = 0, sig = 0, ship = 0;
    logic [W-1:0]  word_q, word_q_o;
    logic          fa, fb, fc, fa_o, fb_o, fc_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;
    logic [W-1:0] expw;

    always #2.5 clk = ~clk;

    word_flag_unit #(.OUT_DOCK(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .ondeck_load(od_load), .ondeck_shift_form(od_shift),
        .ondeck_ones_fill(od_fill), .ondeck_imm(od_imm), .exe_lit_load(ex_lit),
        .exe_lit_shift(ex_shift), .exe_word_capture(ex_cap), .word_in(din),
        .exe_flag_update(ex_flags), .a_select(sel_a), .b_select(sel_b),
        .exe_transfer(ex_move), .xfer_data_in(di), .xfer_token_in(ti),
        .pkt_signal(sig), .ship_status(ship), .word_q(word_q),
        .flag_a(fa), .flag_b(fb), .flag_c(fc));

    word_flag_unit #(.OUT_DOCK(1'b1)) u_dut_out (
        .clk(clk), .rst_n(rst_n), .ondeck_load(od_load), .ondeck_shift_form(od_shift),
        .ondeck_ones_fill(od_fill), .ondeck_imm(od_imm), .exe_lit_load(ex_lit),
        .exe_lit_shift(ex_shift), .exe_word_capture(ex_cap), .word_in(din),
        .exe_flag_update(ex_flags), .a_select(sel_a), .b_select(sel_b),
        .exe_transfer(ex_move), .xfer_data_in(di), .xfer_token_in(ti),
        .pkt_signal(sig), .ship_status(ship), .word_q(word_q_o),
        .flag_a(fa_o), .flag_b(fb_o), .flag_c(fc_o));

    // Flag vectors: [20] update, [19:14] A select, [13:8] B select, [7] transfer,
    // [6] data-in, [5] token-in, [4] signal, [3] status, [2:0] expected A,B,C.
    localparam logic [20:0] FVEC [0:10] = '{
        {1'b1, 6'b010000, 6'b000000, 5'b00000, 3'b100},  // R7 not-A, empty
        {1'b1, 6'b000100, 6'b100000, 5'b00000, 3'b110},  // R9 from old
        {1'b0, 6'b000000, 6'b000000, 5'b11011, 3'b111},  // R10 data-in
        {1'b1, 6'b000010, 6'b000001, 5'b00000, 3'b101},  // R7 C terms
        {1'b1, 6'b001000, 6'b100000, 5'b00000, 3'b011},  // R9 swap
        {1'b0, 6'b000000, 6'b000000, 5'b10001, 3'b011},  // R12 hold
        {1'b0, 6'b000000, 6'b000000, 5'b10101, 3'b010},  // R10 token-in, status ignored
        {1'b1, 6'b110000, 6'b001100, 5'b00000, 3'b110},  // R8 complement
        {1'b1, 6'b100000, 6'b001000, 5'b00000, 3'b110},  // R8 self no-op
        {1'b1, 6'b000000, 6'b000000, 5'b00000, 3'b000},  // R7 all zero
        {1'b1, 6'b000001, 6'b000010, 5'b11010, 3'b101}   // R9 old C seen
    };
    localparam string FTAG [0:10] = '{"R7", "R9", "R10", "R7", "R9", "R12",
                                      "R10", "R8", "R8", "R7", "R9"};

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_strobes();
        od_load = 0; ex_lit = 0; ex_shift = 0; ex_cap = 0;
        ex_flags = 0; ex_move = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset word", 64'(word_q), 64'h0);
        check("R1", "reset flags", 64'({fa, fb, fc}), 64'h0);
        check("R1", "reset out word", 64'(word_q_o), 64'h0);
        check("R1", "reset out flags", 64'({fa_o, fb_o, fc_o}), 64'h0);
        rst_n = 1;

        // R3 with junk in upper literal bits; R2 literal changes after staging
        @(negedge clk); od_load = 1; od_shift = 0; od_fill = 0; od_imm = 19'h71ABC;
        @(negedge clk); clear_strobes(); od_imm = 19'h7FFFF; od_fill = 1; od_shift = 1;
        check("R2", "staging alone", 64'(word_q), 64'h0);
        ex_lit = 1;
        @(negedge clk); clear_strobes();
        check("R3", "zero pad", 64'(word_q), 64'({24'h0, 13'h1ABC}));

        // R4 ones padding
        od_load = 1; od_shift = 0; od_fill = 1; od_imm = 19'h00123;
        @(negedge clk); clear_strobes(); ex_lit = 1;
        @(negedge clk); clear_strobes();
        check("R4", "ones pad", 64'(word_q), 64'({{24{1'b1}}, 13'h0123}));

        // R5 two successive shift-ins
        expw = word_q;
        od_load = 1; od_shift = 1; od_imm = 19'h5A5A5;
        @(negedge clk); clear_strobes(); ex_shift = 1;
        @(negedge clk); clear_strobes();
        expw = {expw[17:0], 19'h5A5A5};
        check("R5", "shift 1", 64'(word_q), 64'(expw));
        od_load = 1; od_shift = 1; od_imm = 19'h00001;
        @(negedge clk); clear_strobes(); od_imm = 19'h3C3C3; ex_shift = 1;
        @(negedge clk); clear_strobes();
        expw = {expw[17:0], 19'h00001};
        check("R5", "shift 2", 64'(word_q), 64'(expw));

        // R6 capture
        din = 37'h15_5555_5555; ex_cap = 1;
        @(negedge clk); clear_strobes();
        check("R6", "capture", 64'(word_q), 64'(37'h15_5555_5555));

        // R13 priority and hold
        od_load = 1; od_shift = 0; od_fill = 0; od_imm = 19'h00007;
        @(negedge clk); clear_strobes();
        ex_lit = 1; ex_shift = 1; ex_cap = 1; din = 37'h0F_0F0F_0F0F;
        @(negedge clk); clear_strobes();
        check("R13", "literal wins", 64'(word_q), 64'h7);
        ex_shift = 1; ex_cap = 1; din = 37'h1F_FFFF_FFFF;
        @(negedge clk); clear_strobes();
        expw = {18'h7, 19'h7};
        check("R13", "shift beats capture", 64'(word_q), 64'(expw));
        din = 37'h0A_AAAA_AAAA;
        @(negedge clk);
        check("R13", "idle hold", 64'(word_q), 64'(expw));

        // Flag table walk, each vector chained on the previous state
        for (int i = 0; i <= 10; i++) begin
            ex_flags = FVEC[i][20];
            sel_a    = FVEC[i][19:14];
            sel_b    = FVEC[i][13:8];
            ex_move  = FVEC[i][7];
            di       = FVEC[i][6];
            ti       = FVEC[i][5];
            sig      = FVEC[i][4];
            ship     = FVEC[i][3];
            @(negedge clk); clear_strobes();
            check(FTAG[i], $sformatf("flag vector %0d", i),
                  64'({fa, fb, fc}), 64'(FVEC[i][2:0]));
        end

        // R11 outward dock C source
        ex_move = 1; di = 1; ti = 0; sig = 0; ship = 1;
        @(negedge clk); clear_strobes();
        check("R11", "out data-in status 1", 64'(fc_o), 64'h1);
        ex_move = 1; di = 0; ti = 1; sig = 0; ship = 1;
        @(negedge clk); clear_strobes();
        check("R11", "out token-in signal 0", 64'(fc_o), 64'h0);
        ex_move = 1; di = 1; ti = 1; sig = 1; ship = 0;
        @(negedge clk); clear_strobes();
        check("R11", "out data-in status 0", 64'(fc_o), 64'h0);
        ex_move = 1; di = 0; ti = 1; sig = 1; ship = 0;
        @(negedge clk); clear_strobes();
        check("R11", "out token-in signal 1", 64'(fc_o), 64'h1);
        ex_move = 1; di = 0; ti = 0; sig = 0; ship = 0;
        @(negedge clk); clear_strobes();
        check("R12", "out hold", 64'(fc_o), 64'h1);

        // R1 reset from a nonzero state
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check("R1", "re-reset word", 64'(word_q), 64'h0);
        check("R1", "re-reset out flags", 64'({fa_o, fb_o, fc_o}), 64'h0);

        done = 1;
        finish_run();
    end

endmodule